// File: doc/BRIEF.md
# Receive Pair Polarity Corrector

This block sits behind the receive front end of a 10BASE-T port. It determines whether the received twisted pair is wired backwards and undoes the swap. The front end delivers one-cycle strobes for qualified events. These are a link pulse seen in the normal sense, a link pulse seen inverted, a frame end whose start-of-idle is normal, a frame end whose start-of-idle is inverted, and valid-data activity. All strobes describe the signal as it appears on the wire, before any correction. The block also takes the link-fail indication and the link-test enable.

Two independent evidence counters accumulate signs of a swapped pair. One counts link pulses and the other counts frame ends. Each counter judges an event as expected or opposite against the polarity currently in force, so a second swap can be detected after a correction. When either counter reaches its limit, the polarity state toggles and both counters restart. While the link is failed, a long quiet interval returns the state to non-inverted. The state XORs the received data and is reported on a status bit.

Top module: `rx_polarity_fixer`

## Requirements
- R1: With link testing enabled, LP_THRESH (default 8) consecutive opposite-sense link pulses toggle the polarity state on the clock edge that takes the last one. An opposite-sense link pulse is `lp_inv` while `pol_inv`=0, or `lp_norm` while `pol_inv`=1.
- R2: EOF_THRESH (default 4) frame ends with an opposite-sense start-of-idle (`eof_inv` while `pol_inv`=0, `eof_norm` while `pol_inv`=1) toggle the polarity state. Frame evidence counts whatever the link-test setting.
- R3: An expected-sense link pulse returns the link-pulse count to zero. An expected-sense frame end returns the frame count to zero.
- R4: Every toggle of the polarity state returns both evidence counts to zero.
- R5: Expected and opposite are judged against the current state. After a toggle to inverted, the same rules detect a swap back to normal.
- R6: While `link_fail`=1, FAIL_CYC consecutive cycles with none of `data_valid`, `lp_norm` or `lp_inv` drive `pol_inv` to 0 at the next edge and clear both counts. Any of those three strobes restarts the interval. With `link_fail`=0 nothing times out.
- R7: With `lt_enable`=0, link pulses of either sense have no effect on polarity, and the link-pulse count is held at zero.
- R8: `rx_data_out` equals `rx_data_in` XOR `pol_inv` in every cycle. `pol_status` equals `pol_inv`.
- R9: Reset (`rst_n`=0) leaves `pol_inv`=0 and both counts at zero.
- R10: When the quiet-interval timeout and an evidence toggle fall in the same cycle, the timeout wins and `pol_inv` becomes 0.
- R11: An expected-sense and an opposite-sense event of the same kind in the same cycle count as expected, so the count clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_enable | input | 1 | Link integrity testing enabled |
| link_fail | input | 1 | Link is in the failed state |
| lp_norm | input | 1 | Link pulse seen with normal sense |
| lp_inv | input | 1 | Link pulse seen with inverted sense |
| eof_norm | input | 1 | Frame end with normal start-of-idle |
| eof_inv | input | 1 | Frame end with inverted start-of-idle |
| data_valid | input | 1 | Valid receive data activity |
| rx_data_in | input | DW | Received data before correction |
| rx_data_out | output | DW | Received data after correction |
| pol_inv | output | 1 | Inversion control currently applied |
| pol_status | output | 1 | Polarity-reversed status bit |

## Verification
Two functions can collide in one cycle: the quiet-interval timeout during link fail, and an evidence toggle caused by a frame end. A frame-end strobe without `data_valid` does not restart the interval. The bench therefore builds the frame count up to one below its limit, raises `link_fail`, and waits exactly FAIL_CYC-1 quiet cycles. It then delivers the final inverted frame end on the expiry cycle. `pol_inv` must read 0 rather than 1, and three further inverted frame ends must not toggle it, which shows that the timeout also cleared the evidence.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

    // Action applied to the polarity state in one cycle
    typedef enum logic [1:0] {
        ACT_KEEP    = 2'd0,
        ACT_TOGGLE  = 2'd1,
        ACT_RESTORE = 2'd2
    } pol_act_e;

    // One kind of event, already oriented against the current state
    typedef struct packed {
        logic exp_hit;
        logic opp_hit;
    } ev_pair_t;

    // Picks the wire-sense strobe that counts as "expected" for a state
    function automatic logic orient(input logic inv, input logic as_normal, input logic as_inverted);
        return inv ? as_inverted : as_normal;
    endfunction

endpackage

// File: rtl/rxpol_evcount.sv
module rxpol_evcount
    import rxpol_pkg::*;
#(
    parameter int THRESH = 8,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  ev_pair_t      pair,
    input  logic          flush,
    output logic          trip,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ecnt_t;

    ecnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        trip = enable && pair.opp_hit && !pair.exp_hit && (st_q.cnt == LAST);
        if (!enable || flush || pair.exp_hit) begin
            st_d.cnt = '0;
        end else if (pair.opp_hit) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/rxpol_failtimer.sv
module rxpol_failtimer #(
    parameter int FAIL_CYC = 64,
    parameter int TW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_fail,
    input  logic          activity,
    output logic          expire,
    output logic [TW-1:0] cnt
);

    localparam logic [TW-1:0] LAST = TW'(FAIL_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic quiet;

    always_comb begin
        st_d   = st_q;
        quiet  = link_fail && !activity;
        expire = quiet && (st_q.cnt == LAST);
        if (!quiet || expire) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/rxpol_state.sv
module rxpol_state
    import rxpol_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pol_act_e act,
    output logic     inv
);

    typedef struct packed {
        logic inv;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_TOGGLE:  st_d.inv = !st_q.inv;
            ACT_RESTORE: st_d.inv = 1'b0;
            default:     st_d.inv = st_q.inv;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inv = st_q.inv;

endmodule

// File: rtl/rx_polarity_fixer.sv
module rx_polarity_fixer
    import rxpol_pkg::*;
#(
    parameter int LP_THRESH  = 8,
    parameter int EOF_THRESH = 4,
    parameter int FAIL_CYC   = 1920000,
    parameter int DW         = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lt_enable,
    input  logic          link_fail,
    input  logic          lp_norm,
    input  logic          lp_inv,
    input  logic          eof_norm,
    input  logic          eof_inv,
    input  logic          data_valid,
    input  logic [DW-1:0] rx_data_in,
    output logic [DW-1:0] rx_data_out,
    output logic          pol_inv,
    output logic          pol_status
);

    localparam int MAX_TH  = (LP_THRESH > EOF_THRESH) ? LP_THRESH : EOF_THRESH;
    localparam int CW      = $clog2(MAX_TH + 1);
    localparam int TW      = $clog2(FAIL_CYC + 1);
    localparam int N_KINDS = 2;

    logic           inv;
    ev_pair_t       pair    [N_KINDS];
    logic           kind_en [N_KINDS];
    logic [CW-1:0]  ev_cnt  [N_KINDS];
    logic [N_KINDS-1:0] trip;
    logic           expire;
    logic [TW-1:0]  fail_cnt;
    logic           flush;
    logic           activity;
    pol_act_e       act;

    // Orient wire-sense strobes against the polarity in force
    always_comb begin
        pair[0].exp_hit = orient(inv, lp_norm, lp_inv);
        pair[0].opp_hit = orient(inv, lp_inv, lp_norm);
        pair[1].exp_hit = orient(inv, eof_norm, eof_inv);
        pair[1].opp_hit = orient(inv, eof_inv, eof_norm);
        kind_en[0]      = lt_enable;
        kind_en[1]      = 1'b1;
        activity        = data_valid || lp_norm || lp_inv;
    end

    // Kind 0: link pulses, kind 1: frame ends
    for (genvar g = 0; g < N_KINDS; g++) begin : g_ev
        localparam int TH = (g == 0) ? LP_THRESH : EOF_THRESH;
        rxpol_evcount #(
            .THRESH (TH),
            .CW     (CW)
        ) cnt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (kind_en[g]),
            .pair   (pair[g]),
            .flush  (flush),
            .trip   (trip[g]),
            .cnt    (ev_cnt[g])
        );
    end

    rxpol_failtimer #(
        .FAIL_CYC (FAIL_CYC),
        .TW       (TW)
    ) tmr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_fail (link_fail),
        .activity  (activity),
        .expire    (expire),
        .cnt       (fail_cnt)
    );

    // Timeout has priority over an evidence toggle
    always_comb begin
        flush = expire || (|trip);
        if (expire) begin
            act = ACT_RESTORE;
        end else if (|trip) begin
            act = ACT_TOGGLE;
        end else begin
            act = ACT_KEEP;
        end
    end

    rxpol_state st_i (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .inv   (inv)
    );

    assign pol_inv     = inv;
    assign pol_status  = inv;
    assign rx_data_out = rx_data_in ^ {DW{inv}};

endmodule

// File: rtl/rxpol_checker.sv
module rxpol_checker #(
    parameter int LP_THRESH  = 8,
    parameter int EOF_THRESH = 4,
    parameter int CW         = 4,
    parameter int TW         = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lt_enable,
    input logic          link_fail,
    input logic          pol_inv,
    input logic [1:0]    trip,
    input logic          expire,
    input logic [CW-1:0] lp_cnt,
    input logic [CW-1:0] eof_cnt,
    input logic [TW-1:0] fail_cnt
);

    AST_LP_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        lp_cnt < CW'(LP_THRESH)); // R1

    AST_EOF_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        eof_cnt < CW'(EOF_THRESH)); // R2

    AST_TOGGLE_CLEARS_EVIDENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip) |=> (lp_cnt == '0) && (eof_cnt == '0)); // R4

    AST_CHANGE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_inv) |-> $past((|trip) || expire)); // R5

    AST_TIMEOUT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !pol_inv); // R6

    AST_NO_TIMING_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        !link_fail |=> (fail_cnt == '0)); // R6

    AST_LT_OFF_NO_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !lt_enable |=> (lp_cnt == '0)); // R7

    AST_TIMEOUT_BEATS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && (|trip)) |=> !pol_inv); // R10

endmodule

bind rx_polarity_fixer rxpol_checker #(
    .LP_THRESH  (LP_THRESH),
    .EOF_THRESH (EOF_THRESH),
    .CW         (CW),
    .TW         (TW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lt_enable (lt_enable),
    .link_fail (link_fail),
    .pol_inv   (pol_inv),
    .trip      (trip),
    .expire    (expire),
    .lp_cnt    (ev_cnt[0]),
    .eof_cnt   (ev_cnt[1]),
    .fail_cnt  (fail_cnt)
);

// File: tb/rx_polarity_fixer_tb_top.sv
`timescale 1ns/1ps
module rx_polarity_fixer_tb_top;

    localparam int LP_TH  = 8;
    localparam int EOF_TH = 4;
    localparam int FAILC  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lt_enable = 1'b1;
    logic link_fail = 1'b0;
    logic lp_norm = 1'b0, lp_inv = 1'b0, eof_norm = 1'b0, eof_inv = 1'b0, data_valid = 1'b0;
    logic [0:0] rx_data_in = 1'b0;
    logic [0:0] rx_data_out;
    logic pol_inv, pol_status;

    int checks = 0;
    int bad = 0;
    string cur_req = "R9";
    bit done = 0;

    // behavioural reference state
    int m_inv = 0, m_lp = 0, m_eof = 0, m_fail = 0;

    always #2 clk = ~clk;

    rx_polarity_fixer #(
        .LP_THRESH  (LP_TH),
        .EOF_THRESH (EOF_TH),
        .FAIL_CYC   (FAILC),
        .DW         (1)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lt_enable   (lt_enable),
        .link_fail   (link_fail),
        .lp_norm     (lp_norm),
        .lp_inv      (lp_inv),
        .eof_norm    (eof_norm),
        .eof_inv     (eof_inv),
        .data_valid  (data_valid),
        .rx_data_in  (rx_data_in),
        .rx_data_out (rx_data_out),
        .pol_inv     (pol_inv),
        .pol_status  (pol_status)
    );

    // Reference model: advances on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_inv = 0; m_lp = 0; m_eof = 0; m_fail = 0;
        end else begin
            int e_lp, o_lp, e_eof, o_eof, act, tmo, n_lp, n_eof;
            e_lp  = m_inv ? int'(lp_inv) : int'(lp_norm);
            o_lp  = m_inv ? int'(lp_norm) : int'(lp_inv);
            e_eof = m_inv ? int'(eof_inv) : int'(eof_norm);
            o_eof = m_inv ? int'(eof_norm) : int'(eof_inv);
            act   = int'(data_valid | lp_norm | lp_inv);
            tmo   = (link_fail && act == 0 && m_fail == FAILC - 1) ? 1 : 0;
            if (!link_fail || act != 0 || tmo != 0) m_fail = 0;
            else m_fail = m_fail + 1;
            if (!lt_enable || e_lp != 0) n_lp = 0;
            else if (o_lp != 0) n_lp = m_lp + 1;
            else n_lp = m_lp;
            if (e_eof != 0) n_eof = 0;
            else if (o_eof != 0) n_eof = m_eof + 1;
            else n_eof = m_eof;
            if (tmo != 0) begin
                m_inv = 0; m_lp = 0; m_eof = 0;
            end else if (n_lp == LP_TH || n_eof == EOF_TH) begin
                m_inv = 1 - m_inv; m_lp = 0; m_eof = 0;
            end else begin
                m_lp = n_lp; m_eof = n_eof;
            end
        end
    end

    // Cycle compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(pol_inv) != m_inv || pol_status != pol_inv) begin
                bad++;
                $display("FAIL %s: pol_inv=%0d pol_status=%0d expected %0d", cur_req, pol_inv, pol_status, m_inv);
            end
            checks++;
            if (rx_data_out != (rx_data_in ^ 1'(m_inv))) begin
                bad++;
                $display("FAIL R8: rx_data_out=%0d expected %0d", rx_data_out, rx_data_in ^ 1'(m_inv));
            end
        end
    end

    task automatic tick(input logic a, input logic b, input logic c, input logic d, input logic v);
        lp_norm = a; lp_inv = b; eof_norm = c; eof_inv = d; data_valid = v;
        rx_data_in = 1'($urandom_range(0, 1));
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
    endtask

    task automatic lpi(input int n);
        for (int i = 0; i < n; i++) begin tick(0, 1, 0, 0, 0); idle(1); end
    endtask

    task automatic lpn(input int n);
        for (int i = 0; i < n; i++) begin tick(1, 0, 0, 0, 0); idle(1); end
    endtask

    task automatic eofi(input int n);
        for (int i = 0; i < n; i++) begin tick(0, 0, 0, 1, 1); idle(2); end
    endtask

    task automatic eofn(input int n);
        for (int i = 0; i < n; i++) begin tick(0, 0, 1, 0, 1); idle(2); end
    endtask

    task automatic dcheck(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        dcheck("R9", pol_inv, 1'b0);
        dcheck("R9", pol_status, 1'b0);
        rst_n = 1'b1;
        idle(2);
        dcheck("R9", pol_inv, 1'b0);

        cur_req = "R1";
        lpi(7);  dcheck("R1", pol_inv, 1'b0);
        lpi(1);  dcheck("R1", pol_inv, 1'b1);
        dcheck("R8", pol_status, 1'b1);

        cur_req = "R5";
        lpn(7);  dcheck("R5", pol_inv, 1'b1);
        lpn(1);  dcheck("R5", pol_inv, 1'b0);

        cur_req = "R3";
        lpi(7); lpn(1); lpi(7);
        dcheck("R3", pol_inv, 1'b0);
        lpi(1);  dcheck("R3", pol_inv, 1'b1);
        lpn(8);  dcheck("R3", pol_inv, 1'b0);

        cur_req = "R11";
        lpi(7); tick(1, 1, 0, 0, 0); idle(1); lpi(7);
        dcheck("R11", pol_inv, 1'b0);
        lpi(1);  dcheck("R11", pol_inv, 1'b1);
        lpn(8);  dcheck("R11", pol_inv, 1'b0);

        cur_req = "R2";
        eofi(3); eofn(1); eofi(3);
        dcheck("R2", pol_inv, 1'b0);
        eofi(1); dcheck("R2", pol_inv, 1'b1);
        eofn(3); dcheck("R5", pol_inv, 1'b1);
        eofn(1); dcheck("R5", pol_inv, 1'b0);

        cur_req = "R4";
        lpi(7); eofi(4);
        dcheck("R4", pol_inv, 1'b1);
        lpn(1);  dcheck("R4", pol_inv, 1'b1);
        lpn(7);  dcheck("R4", pol_inv, 1'b0);

        cur_req = "R7";
        lt_enable = 1'b0;
        lpi(20); dcheck("R7", pol_inv, 1'b0);
        lpi(5);  lt_enable = 1'b1;
        lpi(7);  dcheck("R7", pol_inv, 1'b0);
        lpi(1);  dcheck("R7", pol_inv, 1'b1);
        lpn(8);  dcheck("R7", pol_inv, 1'b0);

        cur_req = "R6";
        eofi(4); dcheck("R6", pol_inv, 1'b1);
        idle(100); dcheck("R6", pol_inv, 1'b1);
        link_fail = 1'b1;
        idle(30); tick(0, 0, 0, 0, 1); idle(FAILC - 1);
        dcheck("R6", pol_inv, 1'b1);
        idle(1); dcheck("R6", pol_inv, 1'b0);
        link_fail = 1'b0;
        idle(2);

        cur_req = "R10";
        eofi(3);
        link_fail = 1'b1;
        idle(FAILC - 1);
        tick(0, 0, 0, 1, 0);
        dcheck("R10", pol_inv, 1'b0);
        link_fail = 1'b0;
        eofi(3); dcheck("R10", pol_inv, 1'b0);
        eofi(1); dcheck("R10", pol_inv, 1'b1);
        eofn(4); dcheck("R10", pol_inv, 1'b0);

        cur_req = "R8";
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 250) lt_enable = ~lt_enable;
            if (i % 150 == 0) link_fail = ~link_fail;
            tick(($urandom_range(0, 11) == 0), ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 29) == 0), ($urandom_range(0, 24) == 0),
                 ($urandom_range(0, 19) == 0));
        end
        idle(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule